// File: doc/BRIEF.md
# Cache Allocation Mask Table

This block keeps the cache capacity bitmasks that the cache allocation logic applies per class of service. Each bit of a mask stands for one minimum portion of the cache, and a set bit means the class may allocate into that portion. Software-side control writes masks through a register-style write port. The block checks every mask before storing it and reports a one-cycle accept or reject pulse. A rejected write leaves the table unchanged.

The allocation logic reads masks through a lookup port. A lookup takes a class index and a fetch type (code or data) and returns the mask one cycle later. A mode input turns on split code/data operation. In that mode the storage is regrouped into pairs, so each class owns a data mask and a code mask, and only the lower half of the class index range is usable. Switching the mode does not clear the table. The same storage is simply read under the other mapping.

Top module: `cat_mask_table`

## Requirements
- R1: After reset every storage entry holds the default mask. In the default mask the low `CBM_LEN` bits are set and every bit at or above `CBM_LEN` is clear. Lookups return this mask for every usable class and both fetch types, in either mode.
- R2: A written mask with any set bit at position `CBM_LEN` or above is rejected.
- R3: A written mask whose set bits do not form one contiguous run is rejected, and the table keeps its previous contents.
- R4: A written mask of zero is rejected.
- R5: Each write produces exactly one status pulse on the cycle after `wr_en` is sampled. `wr_ack` pulses for an accepted write and `wr_err` pulses for a rejected one, and the two are never high together.
- R6: With `split_en` low, class c uses storage entry c. Lookups ignore `lk_code`, and writes ignore `wr_code` and `wr_data`, including when both are high.
- R7: With `split_en` high, class c keeps its data mask in entry 2c and its code mask in entry 2c+1. A lookup with `lk_code`=1 returns the code mask, and one with `lk_code`=0 returns the data mask. The same entries are visible as classes 2c and 2c+1 once `split_en` is low.
- R8: With `split_en` high, a class index at or above `NUM_COS`/2 is rejected. A write to it raises `wr_err`, and a lookup of it raises `lk_err` and returns a zero mask.
- R9: With `split_en` high, `wr_code`=1 with `wr_data`=0 writes only the code mask, and `wr_data`=1 with `wr_code`=0 writes only the data mask. With both low, both masks of the class take the value. With both high, the write is rejected.
- R10: `lk_vld`, `lk_mask` and `lk_err` are registered and appear on the cycle after `lk_req` is sampled. `lk_mask` and `lk_err` hold between lookups.
- R11: A lookup sampled on the same cycle as an accepted write to the same entry returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| split_en | input | 1 | Split code/data mode enable |
| wr_en | input | 1 | Write request |
| wr_cos | input | COS_W | Class index of the write |
| wr_mask | input | MASK_W | Mask value to write |
| wr_code | input | 1 | Split mode: write the code mask only |
| wr_data | input | 1 | Split mode: write the data mask only |
| wr_ack | output | 1 | Write accepted pulse |
| wr_err | output | 1 | Write rejected pulse |
| lk_req | input | 1 | Lookup request |
| lk_cos | input | COS_W | Class index of the lookup |
| lk_code | input | 1 | Fetch type: 1 for code, 0 for data |
| lk_vld | output | 1 | Lookup result valid pulse |
| lk_mask | output | MASK_W | Looked-up mask |
| lk_err | output | 1 | Lookup targeted an unusable class |

## Verification
Write status and lookup results each come one register stage after their request. The bench drives requests on a falling edge and samples on the next falling edge, which is just after the single rising edge that updates `wr_ack`, `wr_err`, `lk_vld`, `lk_mask` and `lk_err`. A table update from an accepted write is visible to a lookup issued on the following cycle, and each write is read back that way. The same-cycle case of R11 is instead sampled one edge after the joint request, and then again after a further lookup.

// File: rtl/cat_mask_pkg.sv
// Shared types for the cache allocation mask table.
// Assumes nothing beyond IEEE 1800-2017 packages.
package cat_mask_pkg;

    // Outcome of validating one write request.
    typedef enum logic [1:0] {
        VERD_OK        = 2'd0,
        VERD_BAD_MASK  = 2'd1,
        VERD_BAD_CLASS = 2'd2,
        VERD_BAD_SEL   = 2'd3
    } wr_verdict_e;

endpackage

// File: rtl/cat_mask_check.sv
// Purely combinational mask validator.
// Reports whether a mask lies inside the configured length, is nonzero,
// and has its set bits in a single contiguous run.
// Assumes CBM_LEN <= MASK_W.
module cat_mask_check #(
    parameter int MASK_W  = 12,
    parameter int CBM_LEN = 10
) (
    input  logic [MASK_W-1:0] mask,
    output logic              in_range,
    output logic              nonzero,
    output logic              contiguous
);
    localparam int EXT_W = MASK_W + 1;

    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] lowest;
    logic [EXT_W-1:0] carried;

    // Range test: upper bits beyond the configured length must be clear.
    generate
        if (CBM_LEN >= MASK_W) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_part
            assign in_range = (mask[MASK_W-1:CBM_LEN] == '0);
        end
    endgenerate

    // Contiguity: adding the lowest set bit clears the whole run if contiguous.
    always_comb begin
        ext        = {1'b0, mask};
        lowest     = ext & (~ext + EXT_W'(1));
        carried    = ext + lowest;
        contiguous = ((carried & ext) == '0);
        nonzero    = (mask != '0);
    end

endmodule

// File: rtl/cat_write_decode.sv
// Turns an approved write into per-entry write enables.
// Flat mode: class c owns entry c. Split mode: entry 2c is data, 2c+1 is code.
// Assumes NUM_COS is even and the caller has already rejected bad requests.
module cat_write_decode #(
    parameter int NUM_COS = 8,
    parameter int COS_W   = 3
) (
    input  logic               go,
    input  logic               split,
    input  logic [COS_W-1:0]   cos,
    input  logic               sel_code,
    input  logic               sel_data,
    output logic [NUM_COS-1:0] we
);
    // Side selection shared by all entries of one parity.
    logic take_code;
    logic take_data;

    // Neither selector means both halves of the pair.
    always_comb begin
        take_code = sel_code || !sel_data;
        take_data = sel_data || !sel_code;
    end

    generate
        for (genvar e = 0; e < NUM_COS; e++) begin : g_ent
            localparam int PAIR = e / 2;
            localparam bit ODD  = (e % 2) == 1;
            logic hit_flat;
            logic hit_pair;
            logic side_ok;
            // Match the request against this entry under both mappings.
            always_comb begin
                hit_flat = (cos == COS_W'(e));
                hit_pair = (cos == COS_W'(PAIR));
                side_ok  = ODD ? take_code : take_data;
                we[e]    = go && (split ? (hit_pair && side_ok) : hit_flat);
            end
        end
    endgenerate

endmodule

// File: rtl/cat_lookup_map.sv
// Maps a lookup class and fetch type onto a storage entry index.
// Flags classes outside the usable half in split mode.
// Assumes NUM_COS is a power of two of at least 4 (COS_W >= 2).
module cat_lookup_map #(
    parameter int COS_W = 3
) (
    input  logic             split,
    input  logic [COS_W-1:0] cos,
    input  logic             is_code,
    output logic [COS_W-1:0] idx,
    output logic             outside
);
    // Pair mapping puts the fetch type in the entry's low bit.
    always_comb begin
        idx     = split ? {cos[COS_W-2:0], is_code} : cos;
        outside = split && cos[COS_W-1];
    end

endmodule

// File: rtl/cat_mask_store.sv
// Mask storage with per-entry write enables and a registered read port.
// Every entry resets to DEFAULT_MASK. A read and a write in the same cycle
// return the entry's old value.
module cat_mask_store #(
    parameter int                NUM_COS      = 8,
    parameter int                MASK_W       = 12,
    parameter int                COS_W        = 3,
    parameter logic [MASK_W-1:0] DEFAULT_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_COS-1:0] we,
    input  logic [MASK_W-1:0]  wdata,
    input  logic               rd_req,
    input  logic [COS_W-1:0]   rd_idx,
    input  logic               rd_block,
    output logic               rd_vld,
    output logic [MASK_W-1:0]  rd_mask,
    output logic               rd_err
);
    logic [MASK_W-1:0] mem [NUM_COS];

    // Entry registers: default on reset, new value on enable.
    generate
        for (genvar e = 0; e < NUM_COS; e++) begin : g_ent
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[e] <= DEFAULT_MASK;
                end else if (we[e]) begin
                    mem[e] <= wdata;
                end
            end
        end
    endgenerate

    // Registered read: zero mask and error flag for a blocked class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld  <= 1'b0;
            rd_mask <= '0;
            rd_err  <= 1'b0;
        end else begin
            rd_vld <= rd_req;
            if (rd_req) begin
                rd_mask <= rd_block ? '0 : mem[rd_idx];
                rd_err  <= rd_block;
            end
        end
    end

endmodule

// File: rtl/cat_mask_table.sv
// Cache capacity mask table indexed by class of service.
// Validates writes (range, nonzero, contiguity, class, selector), stores
// accepted masks, and serves registered lookups in flat or split mode.
// Assumes NUM_COS is a power of two >= 4 and CBM_LEN <= MASK_W.
module cat_mask_table
    import cat_mask_pkg::*;
#(
    parameter int NUM_COS = 8,
    parameter int MASK_W  = 12,
    parameter int CBM_LEN = 10,
    parameter int COS_W   = $clog2(NUM_COS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              split_en,
    input  logic              wr_en,
    input  logic [COS_W-1:0]  wr_cos,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic              wr_code,
    input  logic              wr_data,
    output logic              wr_ack,
    output logic              wr_err,
    input  logic              lk_req,
    input  logic [COS_W-1:0]  lk_cos,
    input  logic              lk_code,
    output logic              lk_vld,
    output logic [MASK_W-1:0] lk_mask,
    output logic              lk_err
);
    localparam logic [MASK_W-1:0] DEFAULT_MASK = {MASK_W{1'b1}} >> (MASK_W - CBM_LEN);

    logic               m_in_range;
    logic               m_nonzero;
    logic               m_contig;
    wr_verdict_e        verdict;
    logic               wr_go;
    logic [NUM_COS-1:0] ent_we;
    logic [COS_W-1:0]   rd_idx;
    logic               rd_outside;

    cat_mask_check #(
        .MASK_W  (MASK_W),
        .CBM_LEN (CBM_LEN)
    ) chk_mask_i (
        .mask       (wr_mask),
        .in_range   (m_in_range),
        .nonzero    (m_nonzero),
        .contiguous (m_contig)
    );

    // Judge the write request: selector, class, then mask shape.
    always_comb begin
        if (split_en && wr_code && wr_data) begin
            verdict = VERD_BAD_SEL;
        end else if (split_en && wr_cos[COS_W-1]) begin
            verdict = VERD_BAD_CLASS;
        end else if (!(m_in_range && m_nonzero && m_contig)) begin
            verdict = VERD_BAD_MASK;
        end else begin
            verdict = VERD_OK;
        end
        wr_go = wr_en && (verdict == VERD_OK);
    end

    cat_write_decode #(
        .NUM_COS (NUM_COS),
        .COS_W   (COS_W)
    ) dec_i (
        .go       (wr_go),
        .split    (split_en),
        .cos      (wr_cos),
        .sel_code (wr_code),
        .sel_data (wr_data),
        .we       (ent_we)
    );

    cat_lookup_map #(
        .COS_W (COS_W)
    ) map_i (
        .split   (split_en),
        .cos     (lk_cos),
        .is_code (lk_code),
        .idx     (rd_idx),
        .outside (rd_outside)
    );

    cat_mask_store #(
        .NUM_COS      (NUM_COS),
        .MASK_W       (MASK_W),
        .COS_W        (COS_W),
        .DEFAULT_MASK (DEFAULT_MASK)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ent_we),
        .wdata    (wr_mask),
        .rd_req   (lk_req),
        .rd_idx   (rd_idx),
        .rd_block (rd_outside),
        .rd_vld   (lk_vld),
        .rd_mask  (lk_mask),
        .rd_err   (lk_err)
    );

    // One-cycle write status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ack <= 1'b0;
            wr_err <= 1'b0;
        end else begin
            wr_ack <= wr_go;
            wr_err <= wr_en && !wr_go;
        end
    end

endmodule

// File: rtl/cat_mask_table_chk.sv
// Assertion checker for the mask table, attached by bind below.
// Observes the top-level ports only.
module cat_mask_table_chk #(
    parameter int NUM_COS = 8,
    parameter int MASK_W  = 12,
    parameter int CBM_LEN = 10,
    parameter int COS_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              split_en,
    input logic              wr_en,
    input logic [COS_W-1:0]  wr_cos,
    input logic [MASK_W-1:0] wr_mask,
    input logic              wr_code,
    input logic              wr_data,
    input logic              wr_ack,
    input logic              wr_err,
    input logic              lk_req,
    input logic [COS_W-1:0]  lk_cos,
    input logic              lk_code,
    input logic              lk_vld,
    input logic [MASK_W-1:0] lk_mask,
    input logic              lk_err
);
    localparam logic [COS_W-1:0] HALF = COS_W'(NUM_COS / 2);

    logic [MASK_W-1:0] high_bits;
    logic              lk_code_seen;

    // Bits of a mask at or above the configured length.
    always_comb begin
        high_bits    = wr_mask >> CBM_LEN;
        lk_code_seen = lk_code;
    end

    assert_status_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ack && wr_err));

    assert_status_due_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_ack || wr_err));

    assert_status_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack || wr_err) |-> $past(wr_en));

    assert_range_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && high_bits != '0) |=> wr_err);

    assert_zero_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mask == '0) |=> wr_err);

    assert_upper_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && split_en && wr_cos >= HALF) |=> wr_err);

    assert_upper_lookup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && split_en && lk_cos >= HALF) |=> (lk_err && lk_mask == '0));

    assert_both_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && split_en && wr_code && wr_data) |=> wr_err);

    assert_lookup_due_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_vld);

    assert_lookup_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> ($stable(lk_mask) && $stable(lk_err)));

    assert_mask_in_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_vld && !lk_err) |-> ((lk_mask >> CBM_LEN) == '0 && lk_mask != '0));

    // lk_code_seen keeps the fetch-type port referenced in the checker.
    assert_code_known_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> !$isunknown(lk_code_seen));

endmodule

bind cat_mask_table cat_mask_table_chk #(
    .NUM_COS (NUM_COS),
    .MASK_W  (MASK_W),
    .CBM_LEN (CBM_LEN),
    .COS_W   (COS_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .split_en (split_en),
    .wr_en    (wr_en),
    .wr_cos   (wr_cos),
    .wr_mask  (wr_mask),
    .wr_code  (wr_code),
    .wr_data  (wr_data),
    .wr_ack   (wr_ack),
    .wr_err   (wr_err),
    .lk_req   (lk_req),
    .lk_cos   (lk_cos),
    .lk_code  (lk_code),
    .lk_vld   (lk_vld),
    .lk_mask  (lk_mask),
    .lk_err   (lk_err)
);

// File: tb/cat_mask_table_tb.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every mask value in flat mode and every
// class/selector combination over chosen masks in split mode, against a
// bench-side model of the storage entries.
module cat_mask_table_tb_top;
    localparam int NUM_COS = 8;
    localparam int MASK_W  = 12;
    localparam int CBM_LEN = 10;
    localparam int COS_W   = 3;
    localparam int HALF    = NUM_COS / 2;
    localparam logic [MASK_W-1:0] DEF = 12'h3FF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              split_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [COS_W-1:0]  wr_cos = '0;
    logic [MASK_W-1:0] wr_mask = '0;
    logic              wr_code = 1'b0;
    logic              wr_data = 1'b0;
    logic              wr_ack;
    logic              wr_err;
    logic              lk_req = 1'b0;
    logic [COS_W-1:0]  lk_cos = '0;
    logic              lk_code = 1'b0;
    logic              lk_vld;
    logic [MASK_W-1:0] lk_mask;
    logic              lk_err;

    int checks = 0;
    int errors = 0;
    logic [MASK_W-1:0] model [NUM_COS];

    always #2.5 clk = ~clk;

    cat_mask_table #(
        .NUM_COS (NUM_COS),
        .MASK_W  (MASK_W),
        .CBM_LEN (CBM_LEN),
        .COS_W   (COS_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .split_en (split_en),
        .wr_en (wr_en), .wr_cos (wr_cos), .wr_mask (wr_mask),
        .wr_code (wr_code), .wr_data (wr_data),
        .wr_ack (wr_ack), .wr_err (wr_err),
        .lk_req (lk_req), .lk_cos (lk_cos), .lk_code (lk_code),
        .lk_vld (lk_vld), .lk_mask (lk_mask), .lk_err (lk_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Mask validity from first/last set bit and population count.
    function automatic bit mask_ok(input logic [MASK_W-1:0] m);
        int lo = -1;
        int hi = -1;
        int cnt = 0;
        for (int i = 0; i < MASK_W; i++) begin
            if (m[i]) begin
                if (lo < 0) lo = i;
                hi = i;
                cnt++;
            end
        end
        return (cnt > 0) && (hi < CBM_LEN) && ((hi - lo + 1) == cnt);
    endfunction

    // Write one request, check its status pulse, update the model.
    task automatic do_write(input int cos, input logic [MASK_W-1:0] m,
                            input bit c, input bit d, input string req);
        bit good;
        good = mask_ok(m) && !(split_en && cos >= HALF) && !(split_en && c && d);
        @(negedge clk);
        wr_en = 1'b1; wr_cos = COS_W'(cos); wr_mask = m; wr_code = c; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check(wr_ack == good && wr_err == !good, req, {wr_ack, wr_err}, {good, !good});
        if (good) begin
            if (!split_en) begin
                model[cos] = m;
            end else begin
                if (c || !d) model[2*cos+1] = m;
                if (d || !c) model[2*cos] = m;
            end
        end
    endtask

    // Look up one class and compare with the model.
    task automatic do_lookup(input int cos, input bit c, input string req);
        logic [MASK_W-1:0] exp_m;
        bit exp_e;
        exp_e = split_en && cos >= HALF;
        exp_m = exp_e ? '0 : (split_en ? model[2*cos + int'(c)] : model[cos]);
        @(negedge clk);
        lk_req = 1'b1; lk_cos = COS_W'(cos); lk_code = c;
        @(negedge clk);
        lk_req = 1'b0;
        check(lk_vld && lk_err == exp_e && lk_mask == exp_m, req,
              {lk_vld, lk_err, lk_mask}, {1'b1, exp_e, exp_m});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [MASK_W-1:0] picks [6];
        picks[0] = 12'h001; picks[1] = 12'h3F0; picks[2] = 12'h0C0;
        picks[3] = 12'h201; picks[4] = 12'h400; picks[5] = 12'h000;
        for (int e = 0; e < NUM_COS; e++) model[e] = DEF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, status idle, defaults in both modes.
        check(!wr_ack && !wr_err && !lk_vld, "R1 idle", {wr_ack, wr_err, lk_vld}, 0);
        for (int k = 0; k < NUM_COS; k++) do_lookup(k, k[0], "R1 flat default");
        split_en = 1'b1;
        for (int k = 0; k < HALF; k++) begin
            do_lookup(k, 1'b0, "R1 split data default");
            do_lookup(k, 1'b1, "R1 split code default");
        end
        split_en = 1'b0;

        // R2 R3 R4 R5 R6: every mask value in flat mode, selectors varied.
        for (int m = 0; m < (1 << MASK_W); m++) begin
            do_write(3, MASK_W'(m), m[0], m[1], "R2_R3_R4_R5_R6 flat write");
            do_lookup(3, m[2], "R3_R6 flat readback");
        end

        // R9 R8 R7: split mode over all classes, selectors and chosen masks.
        split_en = 1'b1;
        for (int k = 0; k < NUM_COS; k++) begin
            for (int s = 0; s < 4; s++) begin
                for (int p = 0; p < 6; p++) begin
                    do_write(k, picks[p] ^ MASK_W'(k), s[0], s[1], "R8_R9 split write");
                    do_lookup(k, 1'b0, "R7_R8 split data");
                    do_lookup(k, 1'b1, "R7_R8 split code");
                end
            end
        end
        // R9: code-only then data-only on class 1.
        do_write(1, 12'h00C, 1'b1, 1'b0, "R9 code only");
        do_lookup(1, 1'b1, "R9 code updated");
        do_lookup(1, 1'b0, "R9 data kept");
        do_write(1, 12'h300, 1'b0, 1'b1, "R9 data only");
        do_lookup(1, 1'b0, "R9 data updated");
        do_lookup(1, 1'b1, "R9 code kept");

        // R7: pair placement seen through the flat mapping.
        split_en = 1'b0;
        for (int k = 0; k < NUM_COS; k++) do_lookup(k, 1'b1, "R7 flat view of pairs");

        // R11: same-cycle write and lookup to class 0 returns old contents.
        @(negedge clk);
        wr_en = 1'b1; wr_cos = '0; wr_mask = 12'h078; wr_code = 1'b0; wr_data = 1'b0;
        lk_req = 1'b1; lk_cos = '0; lk_code = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; lk_req = 1'b0;
        check(lk_mask == model[0] && wr_ack, "R11 old value", lk_mask, model[0]);
        model[0] = 12'h078;
        do_lookup(0, 1'b0, "R11 new value");

        // R10: results hold while no lookup is requested.
        repeat (3) @(negedge clk);
        check(!lk_vld && lk_mask == 12'h078 && !lk_err, "R10 hold",
              {lk_vld, lk_mask}, 12'h078);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule